// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block decides when an I2C target pulls SCL low to stall the bus while software fills its transmit FIFO or drains its receive FIFO. Each FIFO holds at most two bytes. The surrounding target logic supplies a one-cycle pulse for every synchronized SCL falling edge. It also supplies flags that describe the bit about to be driven: the ACK/NACK slot, or the first data bit of a byte, and whether the current byte is the address byte. The block starts a stretch only at those byte-protocol points, and only when the FIFO in use cannot keep up. It drives an open-drain low-enable for SCL.

A 4-bit mode field selects the behaviour:
- Code 0 turns stretching off.
- Codes 1 to 14 give a finite timeout of 2^mode ticks of a prescaled system clock. The timeout does not depend on the I2C bit rate.
- Code 15 lets a stretch last until the FIFO condition clears.

A timeout releases SCL and sets a sticky per-direction flag. A status read clears both flags.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: With mode 0, no SCL falling edge at any point or FIFO level ever asserts `scl_low_en`.
- R2: With mode m in 1..14, a stretch ends at the clock edge that samples the 2^m-th `tick` pulse counted since the stretch began, and that edge sets the sticky flag of the active direction.
- R3: With mode 15, a stretch holds for any number of ticks while its FIFO condition lasts.
- R4: While transmitting (`tgt_tx`=1) with `tx_level`=0, an `scl_fall` pulse sets `scl_low_en` at the next clock edge in two cases: `addr_byte`=1 with `pt_ack`=1, or `addr_byte`=0 with `pt_data`=1. Any other combination leaves SCL free.
- R5: A transmit stretch ends at the clock edge that first samples `tx_level` nonzero.
- R6: While receiving (`tgt_tx`=0), an `scl_fall` pulse with `pt_ack`=1, `addr_byte`=0 and `rx_level`=2 (full) sets `scl_low_en` at the next edge. At a data-bit point, or with a level below 2, no stretch starts.
- R7: A receive stretch ends at the clock edge that first samples `rx_level` below 2.
- R8: `tmo_tx` and `tmo_rx` stay set until a `stat_rd` pulse clears both. A timeout in the same cycle as `stat_rd` leaves its flag set.
- R9: The timeout count advances only on `tick` pulses and restarts from zero at every stretch start.
- R10: If the FIFO condition ends in the same cycle as the final timeout tick, SCL is released and no sticky flag is set.
- R11: After a timeout release, SCL stays free while the FIFO is still unserviced until the next qualifying `scl_fall` decision point.
- R12: A synchronous `rst` clears the stretch, the counter and both sticky flags, even in the middle of a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Stretch mode: 0 off, 1..14 timeout 2^mode ticks, 15 unlimited |
| tgt_tx | input | 1 | 1 when the target transmits, 0 when it receives |
| addr_byte | input | 1 | Current byte is the address byte |
| pt_ack | input | 1 | Next bit is the ACK/NACK slot |
| pt_data | input | 1 | Next bit is the first data bit of a byte |
| scl_fall | input | 1 | One-cycle pulse on a synchronized SCL falling edge |
| tick | input | 1 | One-cycle prescaled timeout tick |
| tx_level | input | 2 | Transmit FIFO byte count, 0..2 |
| rx_level | input | 2 | Receive FIFO byte count, 0..2 (2 = full) |
| stat_rd | input | 1 | One-cycle status read pulse, clears sticky flags |
| scl_low_en | output | 1 | Open-drain enable: 1 pulls SCL low |
| tmo_tx | output | 1 | Sticky transmit-stretch timeout flag |
| tmo_rx | output | 1 | Sticky receive-stretch timeout flag |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the last timeout tick and the FIFO condition clearing. The bench drives `tick` together with a new `tx_level` in one cycle and expects SCL released with `tmo_tx` still clear.

The second pair is a timeout and a status read. The bench raises `stat_rd` on the edge that sees the final tick and expects the flag to come out set rather than lost.

// File: rtl/stretch_pkg.sv
package stretch_pkg;
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    typedef struct packed {
        logic active;
        dir_e dir;
        logic tmo_tx;
        logic tmo_rx;
    } ctl_s;
endpackage

// File: rtl/stretch_trigger.sv
module stretch_trigger #(
    parameter int MODE_W     = 4,
    parameter int LVL_W      = 2,
    parameter int FIFO_DEPTH = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              tgt_tx,
    input  logic              addr_byte,
    input  logic              pt_ack,
    input  logic              pt_data,
    input  logic              scl_fall,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              start
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic enabled;
    logic tx_point;
    logic rx_point;

    always_comb begin
        enabled  = (mode != '0);
        tx_empty = (tx_level == '0);
        rx_full  = (rx_level >= FULL_LVL);
        // transmit: address byte stalls before its ACK slot, data byte before its first bit
        tx_point = addr_byte ? pt_ack : pt_data;
        rx_point = pt_ack && !addr_byte;
        if (tgt_tx) begin
            start = enabled && scl_fall && tx_empty && tx_point;
        end else begin
            start = enabled && scl_fall && rx_full && rx_point;
        end
    end
endmodule

// File: rtl/stretch_timer.sv
module stretch_timer #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              clear,
    input  logic              run,
    input  logic              tick,
    output logic              expire
);
    localparam int                CNT_W    = (1 << MODE_W) - 1;
    localparam logic [MODE_W-1:0] MODE_INF = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   limit;
    logic [CNT_W-1:0] last;

    always_comb begin
        limit  = (CNT_W+1)'(1) << mode;
        last   = CNT_W'(limit - 1'b1);
        expire = run && tick && (mode != MODE_INF) && (cnt_q >= last);
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && tick && !expire) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assert_cnt_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(cnt_q));
    assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
    parameter int MODE_W     = 4,
    parameter int FIFO_DEPTH = 2,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              tgt_tx,
    input  logic              addr_byte,
    input  logic              pt_ack,
    input  logic              pt_data,
    input  logic              scl_fall,
    input  logic              tick,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              stat_rd,
    output logic              scl_low_en,
    output logic              tmo_tx,
    output logic              tmo_rx
);
    import stretch_pkg::*;

    localparam logic [MODE_W-1:0] MODE_INF = '1;

    ctl_s ctl_d, ctl_q;
    logic tx_empty, rx_full, start, expire, hold, clear;

    stretch_trigger #(
        .MODE_W(MODE_W), .LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)
    ) u_trig (
        .mode(mode), .tgt_tx(tgt_tx), .addr_byte(addr_byte),
        .pt_ack(pt_ack), .pt_data(pt_data), .scl_fall(scl_fall),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .rx_full(rx_full), .start(start)
    );

    stretch_timer #(.MODE_W(MODE_W)) u_timer (
        .clk(clk), .rst(rst), .mode(mode), .clear(clear),
        .run(ctl_q.active), .tick(tick), .expire(expire)
    );

    always_comb begin
        hold  = (ctl_q.dir == DIR_TX) ? tx_empty : rx_full;
        clear = start && !ctl_q.active;
        ctl_d = ctl_q;
        if (stat_rd) begin
            ctl_d.tmo_tx = 1'b0;
            ctl_d.tmo_rx = 1'b0;
        end
        if (ctl_q.active) begin
            if (!hold) begin
                // serviced FIFO wins over a coincident timeout
                ctl_d.active = 1'b0;
            end else if (expire) begin
                ctl_d.active = 1'b0;
                if (ctl_q.dir == DIR_TX) ctl_d.tmo_tx = 1'b1;
                else                     ctl_d.tmo_rx = 1'b1;
            end
        end else if (start) begin
            ctl_d.active = 1'b1;
            ctl_d.dir    = tgt_tx ? DIR_TX : DIR_RX;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign scl_low_en = ctl_q.active;
    assign tmo_tx     = ctl_q.tmo_tx;
    assign tmo_rx     = ctl_q.tmo_rx;

    assert_off_stays_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == '0 && !ctl_q.active) |=> !scl_low_en);
    assert_start_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !ctl_q.active) |=> scl_low_en);
    assert_release_on_service_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.active && !hold) |=> (!scl_low_en && $stable({tmo_tx, tmo_rx}) || $past(stat_rd)));
    assert_unlimited_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.active && hold && mode == MODE_INF) |=> scl_low_en);
    assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.active && hold && expire) |=> (!scl_low_en && (tmo_tx || tmo_rx)));
endmodule

// File: tb/tb_i2c_tgt_stretch.sv
module tb_i2c_tgt_stretch;
    logic       clk = 1'b0;
    logic       rst, tgt_tx, addr_byte, pt_ack, pt_data, scl_fall, tick, stat_rd;
    logic [3:0] mode;
    logic [1:0] tx_level, rx_level;
    logic       scl_low_en, tmo_tx, tmo_rx;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    i2c_tgt_stretch dut (
        .clk(clk), .rst(rst), .mode(mode), .tgt_tx(tgt_tx), .addr_byte(addr_byte),
        .pt_ack(pt_ack), .pt_data(pt_data), .scl_fall(scl_fall), .tick(tick),
        .tx_level(tx_level), .rx_level(rx_level), .stat_rd(stat_rd),
        .scl_low_en(scl_low_en), .tmo_tx(tmo_tx), .tmo_rx(tmo_rx)
    );

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic fall(logic is_tx, logic addr, logic ack, logic data);
        tgt_tx = is_tx; addr_byte = addr; pt_ack = ack; pt_data = data; scl_fall = 1'b1;
        cyc();
        scl_fall = 1'b0; pt_ack = 1'b0; pt_data = 1'b0;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            tick = 1'b1;
            cyc();
        end
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc(2); rst = 1'b0; cyc();
    endtask

    task automatic read_status();
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12", "scl after reset", scl_low_en, 1'b0);
        chk("R12", "tmo_tx after reset", tmo_tx, 1'b0);
        chk("R12", "tmo_rx after reset", tmo_rx, 1'b0);
    endtask

    task automatic t_disabled();
        mode = 4'd0; tx_level = 2'd0; rx_level = 2'd2;
        fall(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R1", "tx addr ack point off", scl_low_en, 1'b0);
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R1", "tx data point off", scl_low_en, 1'b0);
        fall(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R1", "rx ack point off", scl_low_en, 1'b0);
    endtask

    task automatic t_tx_points();
        mode = 4'd15; tx_level = 2'd0;
        fall(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R4", "addr byte data point ignored", scl_low_en, 1'b0);
        fall(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R4", "data byte ack point ignored", scl_low_en, 1'b0);
        tx_level = 2'd1;
        fall(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4", "nonempty fifo no stretch", scl_low_en, 1'b0);
        tx_level = 2'd0;
        fall(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4", "addr ack point stretch", scl_low_en, 1'b1);
        cyc(5);
        chk("R5", "still held while empty", scl_low_en, 1'b1);
        tx_level = 2'd2; cyc();
        chk("R5", "release on fill", scl_low_en, 1'b0);
        chk("R5", "no sticky on service", tmo_tx, 1'b0);
        tx_level = 2'd0;
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R4", "data point stretch", scl_low_en, 1'b1);
        tx_level = 2'd1; cyc();
        chk("R5", "release after data point", scl_low_en, 1'b0);
    endtask

    task automatic t_rx();
        mode = 4'd15; rx_level = 2'd1;
        fall(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6", "not full no stretch", scl_low_en, 1'b0);
        rx_level = 2'd2;
        fall(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6", "data point ignored", scl_low_en, 1'b0);
        fall(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6", "full ack point stretch", scl_low_en, 1'b1);
        ticks(40);
        chk("R3", "unlimited mode holds", scl_low_en, 1'b1);
        chk("R3", "no rx sticky", tmo_rx, 1'b0);
        rx_level = 2'd1; cyc();
        chk("R7", "release on drain", scl_low_en, 1'b0);
    endtask

    task automatic t_timeout();
        mode = 4'd3; tx_level = 2'd0;
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        cyc(20);
        chk("R9", "no ticks no timeout", scl_low_en, 1'b1);
        ticks(7);
        chk("R2", "held after 7 of 8 ticks", scl_low_en, 1'b1);
        ticks(1);
        chk("R2", "released on 8th tick", scl_low_en, 1'b0);
        chk("R2", "tmo_tx set", tmo_tx, 1'b1);
        chk("R2", "tmo_rx untouched", tmo_rx, 1'b0);
        cyc(5);
        chk("R8", "sticky holds", tmo_tx, 1'b1);
        chk("R11", "no restretch while empty", scl_low_en, 1'b0);
        fall(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R11", "non-decision fall no stretch", scl_low_en, 1'b0);
        read_status();
        chk("R8", "read clears tmo_tx", tmo_tx, 1'b0);
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R11", "next decision point stretches", scl_low_en, 1'b1);
        tx_level = 2'd1; cyc(); tx_level = 2'd0;
    endtask

    task automatic t_rx_timeout_and_read_race();
        mode = 4'd1; rx_level = 2'd2;
        fall(1'b0, 1'b0, 1'b1, 1'b0);
        ticks(1);
        chk("R2", "rx held after 1 of 2", scl_low_en, 1'b1);
        tick = 1'b1; stat_rd = 1'b1; cyc(); tick = 1'b0; stat_rd = 1'b0;
        chk("R8", "set wins over read", tmo_rx, 1'b1);
        chk("R2", "rx released", scl_low_en, 1'b0);
        read_status();
        chk("R8", "read clears tmo_rx", tmo_rx, 1'b0);
        rx_level = 2'd0;
    endtask

    task automatic t_release_race();
        mode = 4'd1; tx_level = 2'd0;
        fall(1'b1, 1'b1, 1'b1, 1'b0);
        ticks(1);
        tick = 1'b1; tx_level = 2'd1; cyc(); tick = 1'b0;
        chk("R10", "released", scl_low_en, 1'b0);
        chk("R10", "no sticky", tmo_tx, 1'b0);
    endtask

    task automatic t_counter_restart();
        mode = 4'd2; tx_level = 2'd0;
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(3);
        tx_level = 2'd1; cyc(); tx_level = 2'd0;
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(3);
        chk("R9", "count restarted", scl_low_en, 1'b1);
        ticks(1);
        chk("R9", "full length then release", scl_low_en, 1'b0);
        read_status();
    endtask

    task automatic t_reset_mid();
        mode = 4'd1; tx_level = 2'd0;
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(2);
        chk("R12", "timeout before reset", tmo_tx, 1'b1);
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(1);
        rst = 1'b1; cyc(); rst = 1'b0;
        chk("R12", "scl cleared mid stretch", scl_low_en, 1'b0);
        chk("R12", "sticky cleared", tmo_tx, 1'b0);
        fall(1'b1, 1'b0, 1'b0, 1'b1);
        ticks(1);
        chk("R12", "counter cleared by reset", scl_low_en, 1'b1);
        ticks(1);
        chk("R12", "times out after reset", scl_low_en, 1'b0);
    endtask

    initial begin
        rst = 1'b1; mode = 4'd0; tgt_tx = 1'b0; addr_byte = 1'b0; pt_ack = 1'b0;
        pt_data = 1'b0; scl_fall = 1'b0; tick = 1'b0; stat_rd = 1'b0;
        tx_level = 2'd0; rx_level = 2'd0;
        #1;
        t_reset();
        t_disabled();
        t_tx_points();
        t_rx();
        t_timeout();
        t_rx_timeout_and_read_race();
        t_release_race();
        t_counter_restart();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule